// File: doc/BRIEF.md
# Auxiliary System-Control Register Block

This block is a small memory-mapped peripheral that holds a handful of system-control registers behind a simple register bus. The bus has one request per cycle: a register select code, a small offset, lane enables that give the access size, a write flag and write data. Reads answer one cycle later with a valid strobe.

It holds five byte-wide registers: configuration, diagnostic, modem control, aux1 and aux2. It also holds a 16-bit LED register and a 32-bit system-control register.

Three outputs carry side effects:
- a level power-fail interrupt, which is gated by an enable bit in the configuration register;
- a single-cycle floppy terminal-count pulse, fired from aux1;
- a single-cycle system-reset request, fired from the system-control register.

A power-fail input latches a status bit in aux2. That bit survives ordinary aux2 writes and is dropped only by a write-one clear command or by the input falling. A reset leaves the diagnostic, LED and system-control contents untouched.

Top module: `auxctl_regblk`

## Requirements
- R1: While rst_n is low and after it rises, configuration, aux1, aux2 and modem control read 0x00. After reset, pf_irq, fd_tc_pulse and sys_rst_req are low.
- R2: The diagnostic, LED and system-control registers keep their contents through a reset pulse.
- R3: pf_irq is high exactly when aux2 bit 5 (power-fail status) is set and configuration bit 0 (interrupt enable) is set. It follows configuration writes in the cycle after the write.
- R4: When pfail_in changes, aux2 bit 5 becomes pfail_in AND configuration bit 0 at the next clock edge. A change with the enable clear leaves the status bit at 0.
- R5: An aux2 write stores only write-data bit 0 (power-off). All other written bits are discarded, and the current status bit 5 is kept.
- R6: An aux2 write with data bit 2 (interrupt clear) set stores only the written bit 0 and clears status bit 5.
- R7: An aux1 byte write stores the full byte. If data bit 1 is set, fd_tc_pulse is high for exactly one cycle, the cycle after the write. Otherwise no pulse is produced.
- R8: A word write to system control at offset 0 stores the data with bit 0 forced to 0. If data bit 0 is set, sys_rst_req is high for exactly the one cycle after the write.
- R9: The LED register is accessed with a halfword at offset 0. A halfword access at any other offset reads zero and its write has no effect.
- R10: Select codes are 0 config, 1 diag, 2 modem, 3 aux1, 4 aux2, 5 LED, 6 system control. Access sizes are: byte = bus_be 0001 with data in bits 7:0; halfword = 0011 with data in bits 15:0; word = 1111. Any access whose size does not match the register is ignored on write, reads zero, and fires no pulse.
- R11: A read request returns rd_valid high in the next cycle. rd_data then holds the register value as it was when the request was made. rd_valid is low when no read was issued.
- R12: The configuration, diagnostic and modem-control registers store a written byte and return it on read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfail_in | input | 1 | Power-fail indication |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 3 | Register select code |
| bus_off | input | 2 | Byte offset inside the register window |
| bus_be | input | 4 | Lane enables giving the access size |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| pf_irq | output | 1 | Power-fail interrupt level |
| fd_tc_pulse | output | 1 | Floppy terminal-count pulse |
| sys_rst_req | output | 1 | Software system-reset request pulse |

## Verification
The bench builds the block with its default parameters. These are:
- a 32-bit data bus with four lanes;
- a 16-bit LED register;
- status bit 5, clear bit 2, power-off bit 0 and terminal-count bit 1.

With these values, every size mismatch is reachable: a byte register hit with halfword or word lanes, and the wide registers hit with byte lanes or a non-zero offset. The bench also interleaves power-fail edges with enable changes and aux2 clear writes, so it covers the status-bit survival and clear paths. It also puts a reset pulse between writes and reads of the retained registers.

// File: rtl/auxctl_pkg.sv
package auxctl_pkg;
   localparam int AUXCTL_NREG = 7;

   typedef enum logic [2:0] {
      REG_CFG    = 3'd0,
      REG_DIAG   = 3'd1,
      REG_MODEM  = 3'd2,
      REG_AUX1   = 3'd3,
      REG_AUX2   = 3'd4,
      REG_LED    = 3'd5,
      REG_SYSCTL = 3'd6,
      REG_NONE   = 3'd7
   } auxctl_reg_e;
endpackage

// File: rtl/auxctl_decode.sv
// Access legality: one hit bit per register when select, size and offset all match.
module auxctl_decode
   import auxctl_pkg::*;
#(
   parameter int LANES = 4,
   parameter int OFF_W = 2
) (
   input  logic [2:0]             reg_sel,
   input  logic [OFF_W-1:0]       off,
   input  logic [LANES-1:0]       be,
   output logic [AUXCTL_NREG-1:0] hit
);
   localparam logic [LANES-1:0] BE_BYTE = LANES'(1);
   localparam logic [LANES-1:0] BE_HALF = LANES'(3);
   localparam logic [LANES-1:0] BE_WORD = '1;

   for (genvar i = 0; i < AUXCTL_NREG; i++) begin : g_hit
      if (i == int'(REG_LED)) begin : g_half
         assign hit[i] = (reg_sel == 3'(i)) && (be == BE_HALF) && (off == '0);
      end else if (i == int'(REG_SYSCTL)) begin : g_word
         assign hit[i] = (reg_sel == 3'(i)) && (be == BE_WORD) && (off == '0);
      end else begin : g_byte
         assign hit[i] = (reg_sel == 3'(i)) && (be == BE_BYTE);
      end
   end
endmodule

// File: rtl/auxctl_pwrfail.sv
// aux2 storage: power-off bit, sticky power-fail status, interrupt gate.
module auxctl_pwrfail #(
   parameter int BYTE_W   = 8,
   parameter int STAT_BIT = 5,
   parameter int OFF_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pfail_in,
   input  logic              irq_en,
   input  logic              wr_stb,
   input  logic              wr_off,
   input  logic              wr_clr,
   output logic [BYTE_W-1:0] aux2_q,
   output logic              irq
);
   logic              pf_prev;
   logic [BYTE_W-1:0] aux2_nxt;

   always_comb begin
      aux2_nxt = aux2_q;
      if (wr_stb) begin
         aux2_nxt           = '0;
         aux2_nxt[OFF_BIT]  = wr_off;
         aux2_nxt[STAT_BIT] = aux2_q[STAT_BIT] & ~wr_clr;
      end
      if (pfail_in != pf_prev) begin
         aux2_nxt[STAT_BIT] = pfail_in & irq_en;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aux2_q  <= '0;
         pf_prev <= pfail_in;
      end else begin
         aux2_q  <= aux2_nxt;
         pf_prev <= pfail_in;
      end
   end

   assign irq = aux2_q[STAT_BIT] & irq_en;
endmodule

// File: rtl/auxctl_pulse.sv
// Single-cycle strobe register.
module auxctl_pulse (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= fire;
   end
endmodule

// File: rtl/auxctl_regblk.sv
module auxctl_regblk
   import auxctl_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int BYTE_W        = 8,
   parameter int LED_W         = 16,
   parameter int OFF_W         = 2,
   parameter int CFG_EN_BIT    = 0,
   parameter int AUX1_TC_BIT   = 1,
   parameter int AUX2_OFF_BIT  = 0,
   parameter int AUX2_CLR_BIT  = 2,
   parameter int AUX2_STAT_BIT = 5,
   parameter int SYS_RST_BIT   = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pfail_in,
   input  logic                bus_valid,
   input  logic                bus_write,
   input  logic [2:0]          bus_reg,
   input  logic [OFF_W-1:0]    bus_off,
   input  logic [DATA_W/8-1:0] bus_be,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic                rd_valid,
   output logic [DATA_W-1:0]   rd_data,
   output logic                pf_irq,
   output logic                fd_tc_pulse,
   output logic                sys_rst_req
);
   localparam int LANES  = DATA_W / 8;
   localparam int NPULSE = 2;
   localparam logic [DATA_W-1:0] SYS_KEEP = ~(DATA_W'(1) << SYS_RST_BIT);

   // elaboration-time parameter checks
   if (DATA_W % 8 != 0 || LANES < 2) begin : g_bad_data_w
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if (LED_W > DATA_W || LED_W != 16) begin : g_bad_led_w
      $error("LED_W must be 16 and fit in DATA_W");
   end
   if (BYTE_W != 8) begin : g_bad_byte_w
      $error("BYTE_W must be 8");
   end
   if (AUX2_STAT_BIT >= BYTE_W || AUX2_CLR_BIT >= BYTE_W || AUX2_OFF_BIT >= BYTE_W
       || AUX1_TC_BIT >= BYTE_W || CFG_EN_BIT >= BYTE_W) begin : g_bad_bits
      $error("byte register bit positions must fall inside BYTE_W");
   end
   if (SYS_RST_BIT >= DATA_W) begin : g_bad_sysbit
      $error("SYS_RST_BIT outside DATA_W");
   end

   auxctl_reg_e              reg_e;
   logic [AUXCTL_NREG-1:0]   hit;
   logic [AUXCTL_NREG-1:0]   we;
   logic [BYTE_W-1:0]        bdata;
   logic [LED_W-1:0]         hdata;
   logic [BYTE_W-1:0]        cfg_q, modem_q, aux1_q, diag_q, aux2_q;
   logic [LED_W-1:0]         led_q;
   logic [DATA_W-1:0]        sys_q;
   logic [DATA_W-1:0]        rd_mux;
   logic [NPULSE-1:0]        fire, pulse_q;

   assign reg_e = auxctl_reg_e'(bus_reg);
   assign bdata = bus_wdata[BYTE_W-1:0];
   assign hdata = bus_wdata[LED_W-1:0];

   auxctl_decode #(.LANES(LANES), .OFF_W(OFF_W)) u_decode (
      .reg_sel (bus_reg),
      .off     (bus_off),
      .be      (bus_be),
      .hit     (hit)
   );

   assign we = hit & {AUXCTL_NREG{bus_valid & bus_write}};

   // registers cleared by reset
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         modem_q <= '0;
         aux1_q  <= '0;
      end else begin
         if (we[REG_CFG])   cfg_q   <= bdata;
         if (we[REG_MODEM]) modem_q <= bdata;
         if (we[REG_AUX1])  aux1_q  <= bdata;
      end
   end

   // registers that hold their contents through reset
   always_ff @(posedge clk) begin
      if (we[REG_DIAG])   diag_q <= bdata;
      if (we[REG_LED])    led_q  <= hdata;
      if (we[REG_SYSCTL]) sys_q  <= bus_wdata & SYS_KEEP;
   end

   auxctl_pwrfail #(
      .BYTE_W   (BYTE_W),
      .STAT_BIT (AUX2_STAT_BIT),
      .OFF_BIT  (AUX2_OFF_BIT)
   ) u_pwrfail (
      .clk      (clk),
      .rst_n    (rst_n),
      .pfail_in (pfail_in),
      .irq_en   (cfg_q[CFG_EN_BIT]),
      .wr_stb   (we[REG_AUX2]),
      .wr_off   (bdata[AUX2_OFF_BIT]),
      .wr_clr   (bdata[AUX2_CLR_BIT]),
      .aux2_q   (aux2_q),
      .irq      (pf_irq)
   );

   assign fire[0] = we[REG_AUX1]   & bdata[AUX1_TC_BIT];
   assign fire[1] = we[REG_SYSCTL] & bus_wdata[SYS_RST_BIT];

   for (genvar k = 0; k < NPULSE; k++) begin : g_pulse
      auxctl_pulse u_pulse (
         .clk     (clk),
         .rst_n   (rst_n),
         .fire    (fire[k]),
         .pulse_q (pulse_q[k])
      );
   end

   assign fd_tc_pulse = pulse_q[0];
   assign sys_rst_req = pulse_q[1];

   always_comb begin
      rd_mux = '0;
      case (reg_e)
         REG_CFG:    if (hit[REG_CFG])    rd_mux = DATA_W'(cfg_q);
         REG_DIAG:   if (hit[REG_DIAG])   rd_mux = DATA_W'(diag_q);
         REG_MODEM:  if (hit[REG_MODEM])  rd_mux = DATA_W'(modem_q);
         REG_AUX1:   if (hit[REG_AUX1])   rd_mux = DATA_W'(aux1_q);
         REG_AUX2:   if (hit[REG_AUX2])   rd_mux = DATA_W'(aux2_q);
         REG_LED:    if (hit[REG_LED])    rd_mux = DATA_W'(led_q);
         REG_SYSCTL: if (hit[REG_SYSCTL]) rd_mux = sys_q;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= bus_valid & ~bus_write;
         rd_data  <= (bus_valid & ~bus_write) ? rd_mux : '0;
      end
   end
endmodule

// File: rtl/auxctl_regblk_chk.sv
module auxctl_regblk_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pfail_in,
   input logic       bus_valid,
   input logic       bus_write,
   input logic [2:0] bus_reg,
   input logic [1:0] bus_off,
   input logic [3:0] bus_be,
   input logic       wd_tc,
   input logic       wd_rst,
   input logic       rd_valid,
   input logic       pf_irq,
   input logic       fd_tc_pulse,
   input logic       sys_rst_req
);
   AST_TC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fd_tc_pulse |=> !fd_tc_pulse); // R7
   AST_TC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      fd_tc_pulse |-> $past(bus_valid && bus_write && bus_reg == 3'd3 && bus_be == 4'b0001 && wd_tc)); // R7
   AST_SYSRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |=> !sys_rst_req); // R8
   AST_SYSRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |-> $past(bus_valid && bus_write && bus_reg == 3'd6 && bus_be == 4'b1111 && bus_off == 2'd0 && wd_rst)); // R8
   AST_BAD_SIZE_NO_TC: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_reg == 3'd3 && bus_be != 4'b0001) |=> !fd_tc_pulse); // R10
   AST_RD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write) |=> rd_valid); // R11
   AST_RD_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(bus_valid && !bus_write)); // R11
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pf_irq) |-> (($past(pfail_in) && !$past(pfail_in, 2))
                         || $past(bus_valid && bus_write && bus_reg == 3'd0))); // R3
endmodule

bind auxctl_regblk auxctl_regblk_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pfail_in    (pfail_in),
   .bus_valid   (bus_valid),
   .bus_write   (bus_write),
   .bus_reg     (bus_reg),
   .bus_off     (bus_off),
   .bus_be      (bus_be),
   .wd_tc       (bus_wdata[1]),
   .wd_rst      (bus_wdata[0]),
   .rd_valid    (rd_valid),
   .pf_irq      (pf_irq),
   .fd_tc_pulse (fd_tc_pulse),
   .sys_rst_req (sys_rst_req)
);

// File: tb/auxctl_regblk_tb.sv
module auxctl_regblk_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYC   = 20000;

   localparam logic [2:0] R_CFG = 3'd0, R_DIAG = 3'd1, R_MODEM = 3'd2, R_AUX1 = 3'd3,
                          R_AUX2 = 3'd4, R_LED = 3'd5, R_SYS = 3'd6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pfail_in = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [2:0]  bus_reg = '0;
   logic [1:0]  bus_off = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        pf_irq, fd_tc_pulse, sys_rst_req;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] v;
      string       tag;
   } sb_item_t;
   sb_item_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   auxctl_regblk u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .pfail_in    (pfail_in),
      .bus_valid   (bus_valid),
      .bus_write   (bus_write),
      .bus_reg     (bus_reg),
      .bus_off     (bus_off),
      .bus_be      (bus_be),
      .bus_wdata   (bus_wdata),
      .rd_valid    (rd_valid),
      .rd_data     (rd_data),
      .pf_irq      (pf_irq),
      .fd_tc_pulse (fd_tc_pulse),
      .sys_rst_req (sys_rst_req)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_op(input bit wr, input logic [2:0] r, input logic [1:0] off,
                         input logic [3:0] be, input logic [31:0] d);
      bus_valid = 1'b1;
      bus_write = wr;
      bus_reg   = r;
      bus_off   = off;
      bus_be    = be;
      bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0;
      bus_write = 1'b0;
   endtask

   task automatic wr8(input logic [2:0] r, input logic [7:0] d);
      bus_op(1'b1, r, 2'd0, 4'b0001, {24'h0, d});
   endtask

   task automatic rd(input logic [2:0] r, input logic [1:0] off, input logic [3:0] be,
                     input logic [31:0] exp, input string tag);
      sb_item_t it;
      it.v   = exp;
      it.tag = tag;
      sb.push_back(it);
      bus_op(1'b0, r, off, be, 32'h0);
   endtask

   task automatic rd8(input logic [2:0] r, input logic [7:0] exp, input string tag);
      rd(r, 2'd0, 4'b0001, {24'h0, exp}, tag);
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   // monitor: pops the scoreboard for every read response
   initial begin
      forever begin
         @(negedge clk);
         if (rd_valid === 1'b1) begin
            if (sb.size() == 0) begin
               n_chk++;
               n_err++;
               $display("FAIL R11: unexpected read response actual %h expected none", rd_data);
            end else begin
               sb_item_t it;
               it = sb.pop_front();
               chk(rd_data, it.v, it.tag);
            end
         end
      end
   end

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk({31'h0, pf_irq}, 32'h0, "R1 irq after reset");
      chk({31'h0, fd_tc_pulse}, 32'h0, "R1 tc after reset");
      chk({31'h0, sys_rst_req}, 32'h0, "R1 sysrst after reset");
      chk({31'h0, rd_valid}, 32'h0, "R11 idle rd_valid");
      rd8(R_CFG, 8'h00, "R1 cfg reset");
      rd8(R_AUX1, 8'h00, "R1 aux1 reset");
      rd8(R_AUX2, 8'h00, "R1 aux2 reset");
      rd8(R_MODEM, 8'h00, "R1 modem reset");

      // R12 byte registers
      wr8(R_DIAG, 8'hA5);
      wr8(R_MODEM, 8'h3C);
      wr8(R_CFG, 8'h80);
      rd8(R_DIAG, 8'hA5, "R12 diag");
      rd8(R_MODEM, 8'h3C, "R12 modem");
      rd8(R_CFG, 8'h80, "R12 cfg");

      // R9 LED register
      bus_op(1'b1, R_LED, 2'd0, 4'b0011, 32'h0000_BEEF);
      rd(R_LED, 2'd0, 4'b0011, 32'h0000_BEEF, "R9 led readback");
      rd(R_LED, 2'd2, 4'b0011, 32'h0, "R9 led odd offset read");
      bus_op(1'b1, R_LED, 2'd2, 4'b0011, 32'h0000_1234);
      rd(R_LED, 2'd0, 4'b0011, 32'h0000_BEEF, "R9 led odd offset write ignored");

      // R8 system control
      bus_op(1'b1, R_SYS, 2'd0, 4'b1111, 32'hDEAD_BEE1);
      chk({31'h0, sys_rst_req}, 32'h1, "R8 reset pulse high");
      @(negedge clk);
      chk({31'h0, sys_rst_req}, 32'h0, "R8 reset pulse one cycle");
      rd(R_SYS, 2'd0, 4'b1111, 32'hDEAD_BEE0, "R8 sysctl readback bit0 zero");
      rd(R_SYS, 2'd1, 4'b1111, 32'h0, "R8 sysctl nonzero offset");

      // R10 wrong sizes
      bus_op(1'b1, R_CFG, 2'd0, 4'b0011, 32'h0000_0011);
      rd8(R_CFG, 8'h80, "R10 cfg half write ignored");
      rd(R_CFG, 2'd0, 4'b1111, 32'h0, "R10 cfg word read zero");
      bus_op(1'b1, R_AUX1, 2'd0, 4'b1111, 32'h0000_0002);
      chk({31'h0, fd_tc_pulse}, 32'h0, "R10 aux1 word write no pulse");
      rd8(R_AUX1, 8'h00, "R10 aux1 word write ignored");
      bus_op(1'b1, R_SYS, 2'd0, 4'b0001, 32'h0000_0001);
      chk({31'h0, sys_rst_req}, 32'h0, "R10 sysctl byte write no pulse");
      rd(R_SYS, 2'd0, 4'b1111, 32'hDEAD_BEE0, "R10 sysctl byte write ignored");
      rd(R_LED, 2'd0, 4'b0001, 32'h0, "R10 led byte read zero");

      // R7 aux1 terminal count
      wr8(R_AUX1, 8'hFF);
      chk({31'h0, fd_tc_pulse}, 32'h1, "R7 tc pulse high");
      @(negedge clk);
      chk({31'h0, fd_tc_pulse}, 32'h0, "R7 tc pulse one cycle");
      rd8(R_AUX1, 8'hFF, "R7 aux1 full byte");
      wr8(R_AUX1, 8'h01);
      chk({31'h0, fd_tc_pulse}, 32'h0, "R7 no pulse without bit1");
      rd8(R_AUX1, 8'h01, "R7 aux1 byte 01");

      // R4 / R3 power fail with enable
      wr8(R_CFG, 8'h81);
      pfail_in = 1'b1;
      @(negedge clk);
      chk({31'h0, pf_irq}, 32'h1, "R4 irq on pfail with enable");
      rd8(R_AUX2, 8'h20, "R4 status latched");
      wr8(R_CFG, 8'h80);
      chk({31'h0, pf_irq}, 32'h0, "R3 irq masked by enable");
      rd8(R_AUX2, 8'h20, "R3 status kept while masked");
      wr8(R_CFG, 8'h81);
      chk({31'h0, pf_irq}, 32'h1, "R3 irq back on enable");

      // R5 aux2 write masking and status merge
      wr8(R_AUX2, 8'hFB);
      rd8(R_AUX2, 8'h21, "R5 aux2 masked write keeps status");
      chk({31'h0, pf_irq}, 32'h1, "R5 irq survives aux2 write");

      // R6 clear command
      wr8(R_AUX2, 8'h05);
      chk({31'h0, pf_irq}, 32'h0, "R6 irq cleared");
      rd8(R_AUX2, 8'h01, "R6 aux2 keeps only poweroff");

      // R4 change without enable
      pfail_in = 1'b0;
      @(negedge clk);
      wr8(R_CFG, 8'h80);
      pfail_in = 1'b1;
      @(negedge clk);
      chk({31'h0, pf_irq}, 32'h0, "R4 no irq without enable");
      rd8(R_AUX2, 8'h01, "R4 status not latched without enable");
      pfail_in = 1'b0;
      @(negedge clk);
      wr8(R_CFG, 8'h81);
      pfail_in = 1'b1;
      @(negedge clk);
      rd8(R_AUX2, 8'h21, "R4 status set again");
      pfail_in = 1'b0;
      @(negedge clk);
      chk({31'h0, pf_irq}, 32'h0, "R4 falling input clears irq");
      rd8(R_AUX2, 8'h01, "R4 status cleared by falling input");

      // R11 read returns value at request time
      rd8(R_MODEM, 8'h3C, "R11 read before overwrite");
      wr8(R_MODEM, 8'h77);
      rd8(R_MODEM, 8'h77, "R11 read after overwrite");
      @(negedge clk);
      chk({31'h0, rd_valid}, 32'h0, "R11 rd_valid low when idle");

      // R2 / R1 reset pulse
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd8(R_DIAG, 8'hA5, "R2 diag kept");
      rd(R_LED, 2'd0, 4'b0011, 32'h0000_BEEF, "R2 led kept");
      rd(R_SYS, 2'd0, 4'b1111, 32'hDEAD_BEE0, "R2 sysctl kept");
      rd8(R_CFG, 8'h00, "R1 cfg cleared");
      rd8(R_AUX1, 8'h00, "R1 aux1 cleared");
      rd8(R_AUX2, 8'h00, "R1 aux2 cleared");
      rd8(R_MODEM, 8'h00, "R1 modem cleared");

      repeat (3) @(negedge clk);
      chk(32'(sb.size()), 32'h0, "R11 all reads answered");
      done = 1'b1;
      summary();
      $finish;
   end
endmodule